// File: doc/BRIEF.md
# NaN Boxing Operand Handler

This block sits between a 64-bit floating-point register file and a 32-bit single-precision datapath. On the read side it takes two 64-bit register values. It checks that each one holds a properly boxed single-precision value, meaning that all bits above the low 32 are ones. A source that fails the check reaches the datapath as the canonical quiet NaN instead.

On the write side it takes the 32-bit result of an arithmetic unit and builds the 64-bit value that goes back into the register file. A float result first has NaN clean-up applied according to its operation class. The clean-up then fills its upper half with ones. An integer result, such as a compare or a move to an integer register, is sign-extended from bit 31 and is not boxed.

The block is purely combinational, and the arithmetic is outside it. If the operand width is configured to be no narrower than the register width, both the box check and the boxing disappear and values pass straight through.

Top module: `nan_box_unit`

## Requirements
- R1: A source whose bits 63..32 are all ones delivers its bits 31..0 unchanged to the operand output, even when those bits encode a signalling NaN.
- R2: A source with at least one zero among bits 63..32 delivers the canonical single-precision NaN 32'h7FC00000 to the operand output.
- R3: Sources A and B are checked independently. A bad box on one source does not alter the operand derived from the other source.
- R4: When res_is_fp_i is 1, bits 63..32 of wb_o are all ones and bits 31..0 carry the cleaned result.
- R5: When res_is_fp_i is 1 and op_cls_i is 2'd1 (binary rounding), any NaN result is replaced by 32'h7FC00000. A NaN here means exponent bits 30..23 are all ones and mantissa bits 22..0 are nonzero, whatever the sign or the quiet bit.
- R6: When res_is_fp_i is 1 and op_cls_i is 2'd2 (unary rounding), a NaN result with bit 31 set has bit 31 cleared, and its exponent and payload are kept. A NaN result with bit 31 clear is unchanged.
- R7: When res_is_fp_i is 1 and op_cls_i is 2'd0 or 2'd3 (plain move), the result is boxed with no NaN change.
- R8: When res_is_fp_i is 0, wb_o is the result sign-extended from bit 31 and op_cls_i has no effect.
- R9: A float result that is not a NaN, including infinities and zeros, keeps its 32 bits unchanged under every operation class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 64 | First source register value |
| src_b_i | input | 64 | Second source register value |
| res_i | input | 32 | Result from the arithmetic unit |
| res_is_fp_i | input | 1 | 1: result is single-precision float; 0: integer result |
| op_cls_i | input | 2 | 0 plain, 1 binary rounding, 2 unary rounding, 3 plain |
| opnd_a_o | output | 32 | Checked operand from source A |
| opnd_b_o | output | 32 | Checked operand from source B |
| wb_o | output | 64 | Value to write back into the register file |

## Verification
Every output is a function of the current inputs alone, so a wrong decision inside the block shows at the ports in the same cycle as the input that triggers it. Nothing is stored, and so a fault cannot hide for a while and surface later.

A fault in the box check appears as a canonical NaN where a boxed value was expected, or as leaked low bits where a NaN was expected. A fault in the class decode appears as a wrong sign or payload on a NaN, or as a zero-filled or wrongly extended upper half of wb_o. For this reason the stimulus covers negative and signalling NaNs, infinities and single-bit box defects in each class.

// File: rtl/nb_pkg.sv
package nb_pkg;
  localparam int unsigned FP_W  = 32;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned MAN_W = FP_W - EXP_W - 1;
  localparam logic [FP_W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CLS_PLAIN = 2'd0,
    CLS_BIN   = 2'd1,
    CLS_UN    = 2'd2,
    CLS_RSV   = 2'd3
  } cls_e;

  function automatic logic is_nan(input logic [FP_W-1:0] v);
    return (&v[FP_W-2:MAN_W]) && (|v[MAN_W-1:0]);
  endfunction
endpackage

// File: rtl/nb_unbox.sv
module nb_unbox #(
  parameter int unsigned REG_W = 64,
  parameter int unsigned OP_W  = nb_pkg::FP_W
) (
  input  logic [REG_W-1:0] reg_i,
  output logic [OP_W-1:0]  op_o
);
  generate
    if (OP_W < REG_W) begin : g_chk
      logic [OP_W-1:0] op;
      always_comb begin
        op = (&reg_i[REG_W-1:OP_W]) ? reg_i[OP_W-1:0] : nb_pkg::CANON_NAN;
        if (!$isunknown(reg_i)) begin
          AST_UNBOX_GOOD_PASS: assert (!(&reg_i[REG_W-1:OP_W]) || op == reg_i[OP_W-1:0]); // R1
          AST_UNBOX_BAD_CANON: assert ((&reg_i[REG_W-1:OP_W]) || op == nb_pkg::CANON_NAN); // R2
        end
      end
      assign op_o = op;
    end else begin : g_pass
      // no narrowing: no box to check
      assign op_o = reg_i[OP_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/nb_nan_fix.sv
module nb_nan_fix
  import nb_pkg::*;
(
  input  logic [FP_W-1:0] val_i,
  input  cls_e            cls_i,
  output logic [FP_W-1:0] val_o
);
  logic [FP_W-1:0] v;
  always_comb begin
    v = val_i;
    unique case (cls_i)
      CLS_BIN: if (is_nan(val_i)) v = CANON_NAN;
      CLS_UN:  if (is_nan(val_i) && val_i[FP_W-1]) v = {1'b0, val_i[FP_W-2:0]};
      default: v = val_i;
    endcase
    if (!$isunknown({val_i, cls_i})) begin
      AST_FIX_BIN_CANON: assert (!(cls_i == CLS_BIN && is_nan(val_i)) || v == CANON_NAN); // R5
      AST_FIX_UN_NO_NEG_NAN: assert (!(cls_i == CLS_UN) || !(is_nan(v) && v[FP_W-1])); // R6
      AST_FIX_UN_PAYLOAD: assert (!(cls_i == CLS_UN) || v[FP_W-2:0] == val_i[FP_W-2:0]); // R6
      AST_FIX_NONNAN_KEEP: assert (is_nan(val_i) || v == val_i); // R9
    end
  end
  assign val_o = v;
endmodule

// File: rtl/nb_wb_box.sv
module nb_wb_box #(
  parameter int unsigned REG_W = 64,
  parameter int unsigned OP_W  = nb_pkg::FP_W
) (
  input  logic [OP_W-1:0]  fp_val_i,
  input  logic [OP_W-1:0]  int_val_i,
  input  logic             is_fp_i,
  output logic [REG_W-1:0] wb_o
);
  localparam int unsigned PAD_W = (REG_W > OP_W) ? REG_W - OP_W : 1;
  generate
    if (OP_W < REG_W) begin : g_box
      logic [REG_W-1:0] wb;
      always_comb begin
        wb = is_fp_i ? {{PAD_W{1'b1}}, fp_val_i}
                     : {{PAD_W{int_val_i[OP_W-1]}}, int_val_i};
        if (!$isunknown({fp_val_i, int_val_i, is_fp_i})) begin
          AST_BOX_FP_UPPER: assert (!is_fp_i || (&wb[REG_W-1:OP_W] && wb[OP_W-1:0] == fp_val_i)); // R4
          AST_BOX_INT_SEXT: assert (is_fp_i || (wb[OP_W-1:0] == int_val_i &&
                                   wb[REG_W-1:OP_W] == {PAD_W{wb[OP_W-1]}})); // R8
        end
      end
      assign wb_o = wb;
    end else begin : g_flat
      assign wb_o = REG_W'(is_fp_i ? fp_val_i : int_val_i);
    end
  endgenerate
endmodule

// File: rtl/nan_box_unit.sv
module nan_box_unit
  import nb_pkg::*;
#(
  parameter int unsigned REG_W = 64
) (
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [FP_W-1:0]  res_i,
  input  logic             res_is_fp_i,
  input  logic [1:0]       op_cls_i,
  output logic [FP_W-1:0]  opnd_a_o,
  output logic [FP_W-1:0]  opnd_b_o,
  output logic [REG_W-1:0] wb_o
);
  localparam int unsigned NSRC = 2;

  logic [REG_W-1:0] src  [NSRC];
  logic [FP_W-1:0]  opnd [NSRC];
  logic [FP_W-1:0]  res_fixed;

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    nb_unbox #(.REG_W(REG_W), .OP_W(FP_W)) u_unbox (
      .reg_i (src[g]),
      .op_o  (opnd[g])
    );
  end

  assign opnd_a_o = opnd[0];
  assign opnd_b_o = opnd[1];

  nb_nan_fix u_fix (
    .val_i (res_i),
    .cls_i (cls_e'(op_cls_i)),
    .val_o (res_fixed)
  );

  nb_wb_box #(.REG_W(REG_W), .OP_W(FP_W)) u_box (
    .fp_val_i  (res_fixed),
    .int_val_i (res_i),
    .is_fp_i   (res_is_fp_i),
    .wb_o      (wb_o)
  );

  always_comb begin
    if (!$isunknown({src_a_i, opnd_b_o})) begin
      AST_SRC_ISOLATION: assert (!(&src_b_i[REG_W-1:FP_W]) || opnd_b_o == src_b_i[FP_W-1:0]); // R3
    end
  end
endmodule

// File: tb/nan_box_unit_tb_top.sv
module nan_box_unit_tb_top;
  localparam logic [31:0] CANON = 32'h7FC0_0000;
  localparam logic [31:0] ONES  = 32'hFFFF_FFFF;

  typedef struct {
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    logic [63:0] exp_wb;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] src_a, src_b, wb;
  logic [31:0] res, opa, opb;
  logic        is_fp;
  logic [1:0]  cls;

  item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit drv_done = 1'b0;

  nan_box_unit dut_i (
    .src_a_i(src_a), .src_b_i(src_b), .res_i(res), .res_is_fp_i(is_fp),
    .op_cls_i(cls), .opnd_a_o(opa), .opnd_b_o(opb), .wb_o(wb)
  );

  function automatic logic [31:0] m_unbox(input logic [63:0] x);
    return (x[63:32] == ONES) ? x[31:0] : CANON;
  endfunction

  function automatic logic [63:0] m_wb(input logic [31:0] r, input logic fp, input logic [1:0] c);
    logic nan;
    logic [31:0] v;
    if (!fp) return {{32{r[31]}}, r};
    nan = (r[30:23] == 8'hFF) && (r[22:0] != 0);
    v = r;
    if (c == 2'd1 && nan) v = CANON;
    else if (c == 2'd2 && nan && r[31]) v = {1'b0, r[30:0]};
    return {ONES, v};
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [31:0] r,
                       input logic fp, input logic [1:0] c, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    src_a = a; src_b = b; res = r; is_fp = fp; cls = c;
    it.exp_a = m_unbox(a);
    it.exp_b = m_unbox(b);
    it.exp_wb = m_wb(r, fp, c);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (opa !== it.exp_a || opb !== it.exp_b || wb !== it.exp_wb) begin
          n_bad++;
          $display("FAIL %s: got a=%h b=%h wb=%h exp a=%h b=%h wb=%h",
                   it.tag, opa, opb, wb, it.exp_a, it.exp_b, it.exp_wb);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!drv_done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung exp done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : driver
    src_a = '0; src_b = '0; res = '0; is_fp = 1'b0; cls = 2'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-time idle pattern: zero sources are unboxed, integer zero result
    drive(64'h0, 64'h0, 32'h0, 1'b0, 2'd0, "R2 R8 idle");
    drive({ONES, 32'h3F80_0000}, {ONES, 32'hC000_0000}, 32'h4040_0000, 1'b1, 2'd1, "R1 R4 boxed");
    drive({ONES, 32'h7F80_0001}, {ONES, 32'h0000_0000}, 32'h0000_0001, 1'b1, 2'd0, "R1 boxed snan passes");
    drive({32'hFFFF_FFFE, 32'h3F80_0000}, {ONES, 32'h4000_0000}, 32'h0, 1'b1, 2'd0, "R2 R3 bad a");
    drive({ONES, 32'h1234_5678}, {32'h7FFF_FFFF, 32'h4000_0000}, 32'h0, 1'b1, 2'd0, "R2 R3 bad b");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'h7F80_0001, 1'b1, 2'd1, "R5 snan canon");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'hFFC1_2345, 1'b1, 2'd1, "R5 neg qnan canon");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'h7F80_0000, 1'b1, 2'd1, "R9 inf binary");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'hFFC1_2345, 1'b1, 2'd2, "R6 unary neg nan");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'h7FA0_0001, 1'b1, 2'd2, "R6 unary pos nan");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'hFF80_0000, 1'b1, 2'd2, "R9 neg inf unary");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'hFFC1_2345, 1'b1, 2'd0, "R7 plain nan");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'hFFC1_2345, 1'b1, 2'd3, "R7 class3 nan");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'h8000_0001, 1'b0, 2'd1, "R8 int negative");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'h7FC0_0001, 1'b0, 2'd2, "R8 int class ignored");
    drive({ONES, 32'h0}, {ONES, 32'h0}, 32'h8000_0000, 1'b1, 2'd1, "R9 neg zero binary");
    @(posedge clk);
    @(posedge clk);
    drv_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule